// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the program counter of a processor that fetches fixed 32-bit instructions, and picks the counter's next value every clock cycle. There are four candidates. The default is the address of the following instruction. A conditional branch adds a signed offset to that address. An unconditional jump supplies a word index inside the current 256 MB region. A register-indirect jump takes a full address from a register operand.

The instruction decoder drives the block with its decodes: branch-if-equal, branch-if-not-equal, jump and jump-through-register. It also supplies the equality result of the two compared registers, the 16-bit offset field, the 26-bit index field and the register value. The counter moves on every clock edge. Fetch reads the current address from `pc_o`. When the decoder raises more than one decode in the same cycle, a fixed priority picks the next address.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_ni` is low, `pc_o` is 0. It stays 0 until the first rising clock edge after reset is released.
- R2: In a cycle where no jump decode is raised and no branch is taken, the next `pc_o` is the current `pc_o` plus 4.
- R3: With `br_eq_i` high and `ops_equal_i` high, the branch is taken. The next `pc_o` is (`pc_o` + 4) + (sign-extended `br_offset_i` × 4). With `br_eq_i` high and `ops_equal_i` low, the next `pc_o` is `pc_o` + 4.
- R4: With `br_ne_i` high and `ops_equal_i` low, the branch is taken. The next `pc_o` uses the same target formula as R3. With `br_ne_i` high and `ops_equal_i` high, the next `pc_o` is `pc_o` + 4.
- R5: With `jmp_i` high, the next `pc_o` has bits 31:28 from (`pc_o` + 4), bits 27:2 from `jmp_index_i`, and bits 1:0 equal to 0.
- R6: With `jreg_i` high, the next `pc_o` is `jreg_addr_i` with bits 1:0 forced to 0.
- R7: When several decodes are raised together, `jreg_i` wins over `jmp_i`, and `jmp_i` wins over a taken branch. An untaken branch never overrides a jump.
- R8: Bits 1:0 of `pc_o` are 0 in every cycle.
- R9: All address arithmetic wraps modulo 2^32. Stepping from 0xFFFFFFFC gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| br_eq_i | input | 1 | Current instruction is branch-if-equal |
| br_ne_i | input | 1 | Current instruction is branch-if-not-equal |
| ops_equal_i | input | 1 | The two compared registers are equal |
| br_offset_i | input | 16 | Signed branch offset, counted in instructions |
| jmp_i | input | 1 | Current instruction is an unconditional jump |
| jmp_index_i | input | 26 | Word index of the jump target |
| jreg_i | input | 1 | Current instruction jumps through a register |
| jreg_addr_i | input | 32 | Register value used as the indirect target |
| pc_o | output | 32 | Current program counter |

## Verification
The counter is the only state. A wrong next-address choice therefore shows up on `pc_o` at the very next rising edge. Every later address is then off by the same amount, because the sequential step builds on the corrupted value. The bench keeps its own counter model and compares `pc_o` once per cycle between edges. A bad selection, a wrong sign extension, a lost upper nibble or a wrong priority is caught in the cycle it happens. Runs of random decodes mix all the sources with overlapping decodes. Directed cases cover negative offsets, region-crossing jumps, unaligned register targets and wrap-around.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  // Source of the next program counter value
  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_BRANCH = 2'd1,
    SRC_JUMP   = 2'd2,
    SRC_JREG   = 2'd3
  } pc_src_e;
endpackage

// File: rtl/pcu_incr.sv
module pcu_incr #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic [AW-1:0] pc_i,
  output logic [AW-1:0] seq_o
);
  assign seq_o = pc_i + AW'(STEP);
endmodule

// File: rtl/pcu_targets.sv
module pcu_targets #(
  parameter int AW = 32,
  parameter int OW = 16,
  parameter int JW = 26
) (
  input  logic [AW-1:0] seq_i,
  input  logic [OW-1:0] off_i,
  input  logic [JW-1:0] idx_i,
  input  logic [AW-1:0] reg_i,
  output logic [AW-1:0] br_o,
  output logic [AW-1:0] jmp_o,
  output logic [AW-1:0] jr_o
);
  localparam int EXT_W = AW - OW - 2;   // sign bits above the shifted offset
  localparam int HI_W  = AW - JW - 2;   // region bits kept from seq address

  logic [AW-1:0] off_bytes;
  assign off_bytes = {{EXT_W{off_i[OW-1]}}, off_i, 2'b00};
  assign br_o      = seq_i + off_bytes;

  generate
    if (HI_W > 0) begin : g_keep_region
      assign jmp_o = {seq_i[AW-1 -: HI_W], idx_i, 2'b00};
    end else begin : g_full_index
      assign jmp_o = AW'({idx_i, 2'b00});
    end
  endgenerate

  assign jr_o = reg_i & ~AW'(3);
endmodule

// File: rtl/pcu_select.sv
module pcu_select
  import pcu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          beq_i,
  input  logic          bne_i,
  input  logic          eq_i,
  input  logic          jmp_i,
  input  logic          jreg_i,
  input  logic [AW-1:0] seq_i,
  input  logic [AW-1:0] br_i,
  input  logic [AW-1:0] jmp_tgt_i,
  input  logic [AW-1:0] jr_tgt_i,
  output logic [AW-1:0] next_o
);
  pc_src_e src;
  logic    taken;

  assign taken = (beq_i & eq_i) | (bne_i & ~eq_i);

  // Fixed priority: register jump, then jump, then taken branch
  always_comb begin
    if (jreg_i)      src = SRC_JREG;
    else if (jmp_i)  src = SRC_JUMP;
    else if (taken)  src = SRC_BRANCH;
    else             src = SRC_SEQ;
  end

  always_comb begin
    unique case (src)
      SRC_JREG:   next_o = jr_tgt_i;
      SRC_JUMP:   next_o = jmp_tgt_i;
      SRC_BRANCH: next_o = br_i;
      default:    next_o = seq_i;
    endcase
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int AW = 32,
  parameter int OW = 16,
  parameter int JW = 26
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          br_eq_i,
  input  logic          br_ne_i,
  input  logic          ops_equal_i,
  input  logic [OW-1:0] br_offset_i,
  input  logic          jmp_i,
  input  logic [JW-1:0] jmp_index_i,
  input  logic          jreg_i,
  input  logic [AW-1:0] jreg_addr_i,
  output logic [AW-1:0] pc_o
);
  localparam int INSTR_BYTES = 4;

  logic [AW-1:0] pc_q, pc_d;
  logic [AW-1:0] seq_addr, br_addr, jmp_addr, jr_addr;

  pcu_incr #(.AW(AW), .STEP(INSTR_BYTES)) u_incr (
    .pc_i  (pc_q),
    .seq_o (seq_addr)
  );

  pcu_targets #(.AW(AW), .OW(OW), .JW(JW)) u_tgt (
    .seq_i (seq_addr),
    .off_i (br_offset_i),
    .idx_i (jmp_index_i),
    .reg_i (jreg_addr_i),
    .br_o  (br_addr),
    .jmp_o (jmp_addr),
    .jr_o  (jr_addr)
  );

  pcu_select #(.AW(AW)) u_sel (
    .beq_i     (br_eq_i),
    .bne_i     (br_ne_i),
    .eq_i      (ops_equal_i),
    .jmp_i     (jmp_i),
    .jreg_i    (jreg_i),
    .seq_i     (seq_addr),
    .br_i      (br_addr),
    .jmp_tgt_i (jmp_addr),
    .jr_tgt_i  (jr_addr),
    .next_o    (pc_d)
  );

  // R1: counter register, cleared by reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int AW = 32,
  parameter int OW = 16,
  parameter int JW = 26
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          br_eq_i,
  input logic          br_ne_i,
  input logic          ops_equal_i,
  input logic [OW-1:0] br_offset_i,
  input logic          jmp_i,
  input logic [JW-1:0] jmp_index_i,
  input logic          jreg_i,
  input logic [AW-1:0] jreg_addr_i,
  input logic [AW-1:0] pc_o
);
  localparam int REGION_LSB = JW + 2;

  logic [AW-1:0] seq_now, br_now, jmp_now, region_mask;
  logic          take_now;

  assign seq_now     = pc_o + AW'(4);
  assign br_now      = seq_now + (AW'($signed(br_offset_i)) << 2);
  assign region_mask = ~((AW'(1) << REGION_LSB) - AW'(1));
  assign jmp_now     = (seq_now & region_mask) | (AW'(jmp_index_i) << 2);
  assign take_now    = (br_eq_i && ops_equal_i) || (br_ne_i && !ops_equal_i);

  AST_PC_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_o[1:0] == 2'b00);  // R8

  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!jreg_i && !jmp_i && !take_now) |=> pc_o == $past(seq_now));  // R2

  AST_BEQ_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!jreg_i && !jmp_i && br_eq_i && ops_equal_i) |=> pc_o == $past(br_now));  // R3

  AST_BNE_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!jreg_i && !jmp_i && br_ne_i && !ops_equal_i) |=> pc_o == $past(br_now));  // R4

  AST_JUMP_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!jreg_i && jmp_i) |=> pc_o == $past(jmp_now));  // R5

  AST_JREG_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jreg_i |=> pc_o == ($past(jreg_addr_i) & ~AW'(3)));  // R6
endmodule

bind pc_sequencer pcu_checker #(.AW(AW), .OW(OW), .JW(JW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .br_eq_i     (br_eq_i),
  .br_ne_i     (br_ne_i),
  .ops_equal_i (ops_equal_i),
  .br_offset_i (br_offset_i),
  .jmp_i       (jmp_i),
  .jmp_index_i (jmp_index_i),
  .jreg_i      (jreg_i),
  .jreg_addr_i (jreg_addr_i),
  .pc_o        (pc_o)
);

// File: tb/sim_pc_sequencer.sv
`timescale 1ns/1ps
module sim_pc_sequencer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        br_eq_i = 1'b0, br_ne_i = 1'b0, ops_equal_i = 1'b0;
  logic [15:0] br_offset_i = '0;
  logic        jmp_i = 1'b0;
  logic [25:0] jmp_index_i = '0;
  logic        jreg_i = 1'b0;
  logic [31:0] jreg_addr_i = '0;
  logic [31:0] pc_o;

  int unsigned n_checks = 0;
  int unsigned n_fail = 0;
  bit          done = 1'b0;
  logic [31:0] model_pc = '0;

  pc_sequencer u0 (.*);

  always #10 clk_i = ~clk_i;  // 50 MHz

  function automatic logic [31:0] expect_next(
    input logic [31:0] pc, input logic beq, input logic bne, input logic eq,
    input logic [15:0] off, input logic j, input logic [25:0] idx,
    input logic jr, input logic [31:0] rv);
    logic [31:0] s;
    s = pc + 32'd4;
    if (jr) return {rv[31:2], 2'b00};
    if (j)  return {s[31:28], idx, 2'b00};
    if ((beq && eq) || (bne && !eq)) return s + {{14{off[15]}}, off, 2'b00};
    return s;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // Drive one cycle of decodes at a falling edge, check after the next rising edge
  task automatic step(input string req, input logic beq, input logic bne, input logic eq,
                      input logic [15:0] off, input logic j, input logic [25:0] idx,
                      input logic jr, input logic [31:0] rv);
    logic [31:0] exp;
    br_eq_i = beq; br_ne_i = bne; ops_equal_i = eq; br_offset_i = off;
    jmp_i = j; jmp_index_i = idx; jreg_i = jr; jreg_addr_i = rv;
    exp = expect_next(model_pc, beq, bne, eq, off, j, idx, jr, rv);
    @(posedge clk_i);
    @(negedge clk_i);
    check(req, pc_o, exp);
    check("R8", {30'd0, pc_o[1:0]}, 32'd0);
    model_pc = exp;
  endtask

  task automatic seq_step(input string req);
    step(req, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 26'h0, 1'b0, 32'h0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // R1: reset holds the counter at zero
    repeat (3) @(negedge clk_i);
    check("R1 in reset", pc_o, 32'd0);
    rst_ni = 1'b1;
    #2;
    check("R1 after release", pc_o, 32'd0);
    @(negedge clk_i);
    // the edge after release with no decodes already stepped once
    check("R1/R2 first step", pc_o, 32'd4);
    model_pc = 32'd4;

    seq_step("R2 sequential");
    seq_step("R2 sequential");
    step("R3 beq taken fwd",     1, 0, 1, 16'h0003, 0, 26'h0, 0, 32'h0);
    step("R3 beq not taken",     1, 0, 0, 16'h0040, 0, 26'h0, 0, 32'h0);
    step("R3 beq taken back",    1, 0, 1, 16'hFFFE, 0, 26'h0, 0, 32'h0);
    step("R4 bne taken",         0, 1, 0, 16'h0010, 0, 26'h0, 0, 32'h0);
    step("R4 bne not taken",     0, 1, 1, 16'h0010, 0, 26'h0, 0, 32'h0);
    step("R6 jreg unaligned",    0, 0, 0, 16'h0,    0, 26'h0, 1, 32'hA000_0007);
    step("R5 jump keeps region", 0, 0, 0, 16'h0,    1, 26'h3FF_FFFF, 0, 32'h0);
    // R5: the region bits come from the following address; it crosses into 0xB...
    check("R5 region crossing",  pc_o, 32'hAFFF_FFFC);
    step("R5 jump next region",  0, 0, 0, 16'h0,    1, 26'h000_0100, 0, 32'h0);
    check("R5 region value",     pc_o, 32'hB000_0400);
    step("R7 jreg over jump",    1, 0, 1, 16'h0005, 1, 26'h12345, 1, 32'h0000_1002);
    step("R7 jump over branch",  0, 1, 0, 16'h0005, 1, 26'h00042, 0, 32'h0);
    step("R7 untaken br + jump", 1, 0, 0, 16'h0005, 1, 26'h00080, 0, 32'h0);
    step("R9 jreg to top",       0, 0, 0, 16'h0,    0, 26'h0, 1, 32'hFFFF_FFFF);
    seq_step("R9 wrap to zero");
    check("R9 wrapped value", pc_o, 32'd0);
    step("R9 branch below zero", 1, 0, 1, 16'hFFFD, 0, 26'h0, 0, 32'h0);

    // Mid-run reset returns the counter to zero at once (R1)
    @(negedge clk_i);
    model_pc = pc_o;
    rst_ni = 1'b0;
    #2;
    check("R1 async reset", pc_o, 32'd0);
    @(negedge clk_i);
    br_eq_i = 0; br_ne_i = 0; jmp_i = 0; jreg_i = 0;
    rst_ni = 1'b1;
    model_pc = 32'd0;

    // Random mix of decodes, including overlaps (R2..R7)
    for (int i = 0; i < 3000; i++) begin
      int unsigned sel;
      logic b_eq, b_ne, e, jj, jr;
      sel  = $urandom % 10;
      b_eq = (sel inside {1, 2, 7});
      b_ne = (sel inside {3, 4, 8});
      jj   = (sel inside {5, 7, 9});
      jr   = (sel inside {6, 9});
      e    = 1'($urandom);
      step("R2-R7 random", b_eq, b_ne, e, 16'($urandom), jj, 26'($urandom), jr, $urandom);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule